// File: doc/BRIEF.md
# Multi-Mode General Purpose Timer Channel

This block is one timer channel controlled through a small synchronous register bus. A 3-bit mode field selects what the channel does: time-stamp rising edges on an input pin, toggle an output pin when the counter meets a compare value, generate a pulse-width modulated waveform, or run as an internal countdown for periodic CPU ticks or watchdog use. A programmable prescaler sets the counter rate. A stop/continuous bit chooses whether the channel halts once its mode has completed or restarts and repeats it. A counter enable bit starts and stops the count in the internal countdown mode only.

Three event flags record capture, compare and end-of-period events. Software clears each flag by writing a one to it. The interrupt output is raised while an enabled flag is set. In PWM mode the end-of-period flag rises at the start of each new pulse. This leaves software a full pulse in which to write the next width, and the hardware holds that width back until the next pulse begins.

Software sets up the prescale, period and width registers while the mode field is zero, then writes the control register last to arm the channel. Writing the mode field back to zero stops the channel and clears it.

Top module: `gp_timer`

## Requirements
- R1: The control register (address 0) holds mode in bits [2:0], stop/continuous in bit 3 (1 = repeat), counter enable in bit 4 and interrupt enable in bit 5. Mode 000, and the unused values 101 to 111, disable the channel: the counters are held at zero, `tmr_out` is low and every status flag is cleared, starting from the clock edge that writes that mode.
- R2: The status register (address 1) has the input-capture flag at bit 0, the compare flag at bit 1 and the PWM end-of-period flag at bit 2. Writing 1 to a flag clears it. Writing 0 leaves it unchanged. If an event and a clear fall on the same edge, the event wins.
- R3: `tmr_irq` is high exactly when the interrupt enable bit is 1 and at least one status flag is set.
- R4: In input capture mode (001), a rising edge on `tmr_in` passes through a two-flop synchronizer. On the third clock edge after the pin changes, the counter value is copied to the capture register (address 5) and status bit 0 is set.
- R5: In input capture mode with stop/continuous = 0, the channel stops after the first capture. Later edges set no flag and leave the capture register unchanged.
- R6: In output compare mode (010), the counter counts prescaled ticks from 0. On the tick where it equals the period/compare register (address 3), the counter returns to 0, `tmr_out` toggles and status bit 1 is set. With stop/continuous = 1 this repeats every compare+1 ticks.
- R7: In CPU/watchdog mode (100), the counter advances only while counter enable = 1. It expires like R6 and sets status bit 1. With stop/continuous = 0 it halts after the first expiry.
- R8: The counter enable bit has no effect in input capture, output compare and PWM modes.
- R9: The prescaler (address 2) holding value P produces one counter tick every P+1 clock cycles, with the first tick P+1 cycles after arming.
- R10: In PWM mode (011), a period lasts period+1 ticks. `tmr_out` is high for the first `width` ticks of each period (address 4). At the start of each new pulse, status bit 2 is set and the width register is loaded. A width written during a pulse therefore applies only from the next pulse.
- R11: Reads of address 6 (counter) return zero in every mode. The internal count is never visible to software.
- R12: Addresses 2, 3, 4 and the low six bits of address 0 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (3) | Register address |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Combinational read data for `bus_addr` |
| tmr_in | input | 1 | Asynchronous capture input pin |
| tmr_out | output | 1 | Compare / PWM output pin |
| tmr_irq | output | 1 | Interrupt request |

## Verification
The bound checker watches, on every cycle, properties that must hold in any scenario. A disabled channel keeps its counter at zero and its flags clear. A single-shot capture always halts the channel. The count freezes in CPU mode while the counter enable is low. The active PWM width changes only at a period boundary. The counter address always reads zero. Exact timing can only be shown by the bench's scenarios, each placed on a known cycle. These cover the synchronizer latency and the captured value, the compare interval and output toggle, prescaled expiry, and the one-pulse delay before a new width takes effect. They also show that clearing a flag with a one works while writing a zero does not.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

   typedef enum logic [2:0] {
      M_OFF  = 3'd0,
      M_CAPT = 3'd1,
      M_COMP = 3'd2,
      M_PWM  = 3'd3,
      M_CPU  = 3'd4
   } mode_e;

   // control register bit positions
   localparam int CB_SC = 3;
   localparam int CB_CE = 4;
   localparam int CB_IE = 5;

   // status flag positions
   localparam int SB_CAPT = 0;
   localparam int SB_COMP = 1;
   localparam int SB_PWM  = 2;

   // register addresses
   localparam int ADR_CTRL = 0;
   localparam int ADR_STAT = 1;
   localparam int ADR_PSC  = 2;
   localparam int ADR_PER  = 3;
   localparam int ADR_WID  = 4;
   localparam int ADR_CAP  = 5;
   localparam int ADR_CNT  = 6;

   function automatic logic mode_valid(input logic [2:0] m);
      return (m == M_CAPT) || (m == M_COMP) || (m == M_PWM) || (m == M_CPU);
   endfunction

endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise
);
   localparam int LAST = STAGES;

   logic [LAST:0] chain_q;

   for (genvar i = 0; i <= LAST; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign rise = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          run,
   input  logic [PW-1:0] limit,
   output logic          tick
);
   logic [PW-1:0] div_q;
   logic          wrap;

   assign wrap = (div_q == limit);
   assign tick = run && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div_q <= '0;
      else if (clear)   div_q <= '0;
      else if (run)     div_q <= wrap ? '0 : div_q + 1'b1;
   end
endmodule

// File: rtl/gpt_core.sv
module gpt_core
   import gpt_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    mode,
   input  logic          sc,
   input  logic          ce,
   input  logic          tick,
   input  logic [CW-1:0] period,
   input  logic [CW-1:0] width,
   input  logic          pin_rise,
   output logic          run,
   output logic          ev_capt,
   output logic          ev_comp,
   output logic          ev_pwm,
   output logic [CW-1:0] cap_val,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] act_width,
   output logic          halted,
   output logic          out_lvl
);
   logic          active, is_capt, is_comp, is_pwm, is_cpu, at_end;
   logic [CW-1:0] cnt_q, cap_q, actw_q;
   logic          halt_q, oc_q;

   assign active  = mode_valid(mode);
   assign is_capt = active && (mode == M_CAPT);
   assign is_comp = active && (mode == M_COMP);
   assign is_pwm  = active && (mode == M_PWM);
   assign is_cpu  = active && (mode == M_CPU);
   assign at_end  = (cnt_q == period);

   assign run     = active && !halt_q && (!is_cpu || ce);
   assign ev_capt = is_capt && !halt_q && pin_rise;
   assign ev_comp = tick && (is_comp || is_cpu) && at_end;
   assign ev_pwm  = tick && is_pwm && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         cap_q  <= '0;
         actw_q <= '0;
         halt_q <= 1'b0;
         oc_q   <= 1'b0;
      end else if (!active) begin
         cnt_q  <= '0;
         actw_q <= width;
         halt_q <= 1'b0;
         oc_q   <= 1'b0;
      end else begin
         if (tick) begin
            if (at_end && !is_capt) begin
               cnt_q <= '0;
               if (!sc)    halt_q <= 1'b1;
               if (is_comp) oc_q  <= ~oc_q;
               if (is_pwm)  actw_q <= width;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         if (ev_capt) begin
            cap_q <= cnt_q;
            if (!sc) halt_q <= 1'b1;
         end
         if (!is_pwm) actw_q <= width;
      end
   end

   assign out_lvl   = is_pwm ? (!halt_q && (cnt_q < actw_q)) : (is_comp && oc_q);
   assign cap_val   = cap_q;
   assign cnt       = cnt_q;
   assign act_width = actw_q;
   assign halted    = halt_q;
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
   import gpt_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 3,
   parameter int CW = 16,
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [CW-1:0] cap_val,
   input  logic          ev_capt,
   input  logic          ev_comp,
   input  logic          ev_pwm,
   output logic [2:0]    mode,
   output logic          sc,
   output logic          ce,
   output logic          ie,
   output logic [PW-1:0] psc,
   output logic [CW-1:0] period,
   output logic [CW-1:0] width,
   output logic [2:0]    flags,
   output logic          irq
);
   localparam int NFLAG = 3;

   logic [5:0]       ctrl_q;
   logic [PW-1:0]    psc_q;
   logic [CW-1:0]    per_q, wid_q;
   logic [NFLAG-1:0] flag_q, set_v, clr_v;
   logic [2:0]       mode_nxt;
   logic             wr_ctrl, wr_stat;

   assign wr_ctrl  = we && (addr == AW'(ADR_CTRL));
   assign wr_stat  = we && (addr == AW'(ADR_STAT));
   assign mode_nxt = wr_ctrl ? wdata[2:0] : ctrl_q[2:0];

   always_comb begin
      set_v          = '0;
      set_v[SB_CAPT] = ev_capt;
      set_v[SB_COMP] = ev_comp;
      set_v[SB_PWM]  = ev_pwm;
      clr_v          = wr_stat ? wdata[NFLAG-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         psc_q  <= '0;
         per_q  <= '0;
         wid_q  <= '0;
         flag_q <= '0;
      end else begin
         if (wr_ctrl)                     ctrl_q <= wdata[5:0];
         if (we && addr == AW'(ADR_PSC))  psc_q  <= wdata[PW-1:0];
         if (we && addr == AW'(ADR_PER))  per_q  <= wdata[CW-1:0];
         if (we && addr == AW'(ADR_WID))  wid_q  <= wdata[CW-1:0];
         if (!mode_valid(mode_nxt))       flag_q <= '0;
         else                             flag_q <= (flag_q & ~clr_v) | set_v;
      end
   end

   always_comb begin
      case (int'(addr))
         ADR_CTRL: rdata = DW'(ctrl_q);
         ADR_STAT: rdata = DW'(flag_q);
         ADR_PSC:  rdata = DW'(psc_q);
         ADR_PER:  rdata = DW'(per_q);
         ADR_WID:  rdata = DW'(wid_q);
         ADR_CAP:  rdata = DW'(cap_val);
         default:  rdata = '0;
      endcase
   end

   assign mode   = ctrl_q[2:0];
   assign sc     = ctrl_q[CB_SC];
   assign ce     = ctrl_q[CB_CE];
   assign ie     = ctrl_q[CB_IE];
   assign psc    = psc_q;
   assign period = per_q;
   assign width  = wid_q;
   assign flags  = flag_q;
   assign irq    = ie && (|flag_q);
endmodule

// File: rtl/gp_timer.sv
module gp_timer
   import gpt_pkg::*;
#(
   parameter int CW          = 16,
   parameter int PW          = 16,
   parameter int DW          = 16,
   parameter int AW          = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          tmr_in,
   output logic          tmr_out,
   output logic          tmr_irq
);
   if (DW < CW || DW < PW || DW < 6) begin : g_bad_dw
      $error("gp_timer: data width too small for counter, prescaler or control");
   end
   if (AW < 3) begin : g_bad_aw
      $error("gp_timer: address width must cover seven registers");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gp_timer: at least two synchronizer stages required");
   end

   logic [2:0]    mode_w, flags_w;
   logic          sc_w, ce_w, ie_w, tick_w, run_w, rise_w, active_w;
   logic          ev_capt_w, ev_comp_w, ev_pwm_w, halted_w, lvl_w;
   logic [PW-1:0] psc_w;
   logic [CW-1:0] per_w, wid_w, cap_w, cnt_w, actw_w;

   assign active_w = mode_valid(mode_w);

   gpt_regs #(.DW(DW), .AW(AW), .CW(CW), .PW(PW)) u_regs (
      .clk, .rst_n,
      .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
      .cap_val(cap_w), .ev_capt(ev_capt_w), .ev_comp(ev_comp_w), .ev_pwm(ev_pwm_w),
      .mode(mode_w), .sc(sc_w), .ce(ce_w), .ie(ie_w),
      .psc(psc_w), .period(per_w), .width(wid_w),
      .flags(flags_w), .irq(tmr_irq)
   );

   gpt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n, .pin(tmr_in), .rise(rise_w)
   );

   gpt_prescaler #(.PW(PW)) u_psc (
      .clk, .rst_n, .clear(!active_w), .run(run_w), .limit(psc_w), .tick(tick_w)
   );

   gpt_core #(.CW(CW)) u_core (
      .clk, .rst_n, .mode(mode_w), .sc(sc_w), .ce(ce_w), .tick(tick_w),
      .period(per_w), .width(wid_w), .pin_rise(rise_w),
      .run(run_w), .ev_capt(ev_capt_w), .ev_comp(ev_comp_w), .ev_pwm(ev_pwm_w),
      .cap_val(cap_w), .cnt(cnt_w), .act_width(actw_w), .halted(halted_w),
      .out_lvl(lvl_w)
   );

   assign tmr_out = active_w && lvl_w;
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker
   import gpt_pkg::*;
#(
   parameter int CW = 16,
   parameter int DW = 16,
   parameter int AW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_rdata,
   input logic [2:0]    mode,
   input logic          sc,
   input logic          ce,
   input logic          ie,
   input logic [2:0]    flags,
   input logic          irq,
   input logic [CW-1:0] cnt,
   input logic [CW-1:0] act_width,
   input logic          halted,
   input logic          ev_capt,
   input logic          ev_pwm
);
   logic active, pwm_on;
   assign active = mode_valid(mode);
   assign pwm_on = active && (mode == M_PWM);

   a_r1_off_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt == '0));

   a_r1_off_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (flags == 3'b000));

   a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ie);

   a_r5_single_shot_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (active && mode == M_CAPT && !sc && ev_capt) |=> halted);

   a_r7_ce_freezes_count: assert property (@(posedge clk) disable iff (!rst_n)
      (active && mode == M_CPU && !ce) |=> $stable(cnt));

   a_r10_width_held: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_on && $past(pwm_on) && !$past(ev_pwm)) |-> $stable(act_width));

   a_r11_count_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == AW'(ADR_CNT)) |-> (bus_rdata == '0));
endmodule

bind gp_timer gpt_checker #(.CW(CW), .DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .mode(mode_w), .sc(sc_w), .ce(ce_w), .ie(ie_w), .flags(flags_w), .irq(tmr_irq),
   .cnt(cnt_w), .act_width(actw_w), .halted(halted_w),
   .ev_capt(ev_capt_w), .ev_pwm(ev_pwm_w)
);

// File: tb/sim_gp_timer.sv
module sim_gp_timer;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        tmr_in = 1'b0;
   logic        tmr_out, tmr_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int          kind;   // 0 read data, 1 irq, 2 out pin
      logic [15:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   event  mon_ev;

   always #2.5 clk = ~clk;

   gp_timer u0 (
      .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
      .tmr_in, .tmr_out, .tmr_irq
   );

   // monitor: compares what the design shows against queued expectations
   always begin
      @(mon_ev);
      #0.2;
      while (q.size() > 0) begin
         item_t it;
         logic [15:0] obs;
         it = q.pop_front();
         case (it.kind)
            0:       obs = bus_rdata;
            1:       obs = {15'd0, tmr_irq};
            default: obs = {15'd0, tmr_out};
         endcase
         checks++;
         if (obs !== it.exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", it.req, obs, it.exp);
         end
      end
   end

   // driver tasks, called in the low phase of the clock
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic push(input int k, input logic [15:0] e, input string r);
      item_t it;
      it.kind = k;
      it.exp  = e;
      it.req  = r;
      q.push_back(it);
      -> mon_ev;
      #0.4;
   endtask

   task automatic exp_rd(input logic [2:0] a, input logic [15:0] e, input string r);
      bus_addr = a;
      push(0, e, r);
   endtask

   task automatic exp_irq(input logic e, input string r);
      push(1, {15'd0, e}, r);
   endtask

   task automatic exp_out(input logic e, input string r);
      push(2, {15'd0, e}, r);
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // reset state
      exp_rd(1, 16'h0, "R1 reset status");
      exp_rd(0, 16'h0, "R1 reset control");
      exp_irq(1'b0, "R3 reset irq");
      exp_out(1'b0, "R1 reset out");

      // R12 readback
      wr(2, 16'h0000);
      wr(3, 16'h0003);
      wr(4, 16'h0007);
      exp_rd(3, 16'h0003, "R12 period readback");
      exp_rd(4, 16'h0007, "R12 width readback");

      // output compare: mode 010, sc=1, ce=0, ie=1 -> 0x2A; compare 3, prescale 0
      wr(0, 16'h002A);                   // armed at E0
      cyc(3);                            // after E3
      exp_out(1'b0, "R6 out before match");
      exp_rd(1, 16'h0, "R8 no compare flag yet (ce=0 ignored)");
      exp_rd(6, 16'h0, "R11 counter reads zero");
      cyc(1);                            // after E4
      exp_out(1'b1, "R6 toggle on match");
      exp_rd(1, 16'h0002, "R6 compare flag bit1");
      exp_irq(1'b1, "R3 irq with enable");
      wr(1, 16'h0002);                   // clear at E5
      exp_rd(1, 16'h0, "R2 write-one clears");
      exp_irq(1'b0, "R3 irq drops");
      cyc(3);                            // after E8
      exp_out(1'b0, "R6 repeat toggle");
      exp_rd(1, 16'h0002, "R6 repeated compare flag");
      exp_rd(0, 16'h002A, "R12 control readback");
      wr(0, 16'h0000);
      exp_rd(1, 16'h0, "R1 disable clears flag");
      exp_out(1'b0, "R1 disable drives out low");
      exp_irq(1'b0, "R1 disable drops irq");

      // ie=0: flag set but no irq (mode 010, sc=1, ie=0 -> 0x0A)
      wr(0, 16'h000A);
      cyc(4);
      exp_rd(1, 16'h0002, "R3 flag set without enable");
      exp_irq(1'b0, "R3 irq masked");
      wr(0, 16'h0000);

      // CPU mode with prescaler: psc 2, period 1, ce=1, sc=0, ie=1 -> 0x34
      wr(2, 16'h0002);
      wr(3, 16'h0001);
      wr(0, 16'h0034);                   // E0
      cyc(5);                            // after E5
      exp_rd(1, 16'h0, "R9 no expiry before sixth cycle");
      cyc(1);                            // after E6
      exp_rd(1, 16'h0002, "R9 R7 expiry flag on sixth cycle");
      exp_irq(1'b1, "R3 irq on expiry");
      wr(1, 16'h0002);
      cyc(12);
      exp_rd(1, 16'h0, "R7 single expiry halts");
      wr(0, 16'h0000);

      // CPU mode gated by ce: psc 0, period 2, ce=0, sc=1, ie=1 -> 0x2C
      wr(2, 16'h0000);
      wr(3, 16'h0002);
      wr(0, 16'h002C);
      cyc(10);
      exp_rd(1, 16'h0, "R7 ce low freezes countdown");
      wr(0, 16'h003C);                   // ce=1 at Ec
      cyc(2);
      exp_rd(1, 16'h0, "R7 count resumes from zero");
      cyc(1);
      exp_rd(1, 16'h0002, "R7 expiry after enable");
      wr(0, 16'h0000);

      // input capture single-shot: mode 001, sc=0, ie=1 -> 0x21
      tmr_in = 1'b0;
      wr(0, 16'h0021);                   // E0
      cyc(4);                            // negedge after E4
      tmr_in = 1'b1;
      cyc(2);                            // after E6
      exp_rd(1, 16'h0, "R4 synchronizer latency");
      cyc(1);                            // after E7
      exp_rd(1, 16'h0001, "R4 capture flag bit0");
      exp_rd(5, 16'h0006, "R4 captured count");
      wr(1, 16'h0001);
      tmr_in = 1'b0;
      cyc(5);
      tmr_in = 1'b1;
      cyc(6);
      exp_rd(5, 16'h0006, "R5 later edge ignored value");
      exp_rd(1, 16'h0, "R5 later edge no flag");
      tmr_in = 1'b0;
      wr(0, 16'h0000);

      // PWM: period 4, width 2, mode 011, sc=1, ie=1 -> 0x2B
      wr(3, 16'h0004);
      wr(4, 16'h0002);
      wr(0, 16'h002B);                   // E0
      wr(4, 16'h0003);                   // new width at E1
      exp_out(1'b1, "R10 pulse high at start");
      cyc(1);                            // after E2
      exp_out(1'b0, "R10 old width still used");
      cyc(2);                            // after E4
      exp_rd(1, 16'h0, "R10 no flag mid period");
      cyc(1);                            // after E5
      exp_out(1'b1, "R10 new pulse starts");
      exp_rd(1, 16'h0004, "R10 end-of-period flag bit2");
      exp_irq(1'b1, "R10 irq at pulse start");
      cyc(2);                            // after E7
      exp_out(1'b1, "R10 new width applied");
      cyc(1);                            // after E8
      exp_out(1'b0, "R10 pulse ends after new width");
      wr(1, 16'h0003);                   // zero in bit2, at E9
      exp_rd(1, 16'h0004, "R2 writing zero keeps flag");
      wr(0, 16'h0000);
      exp_rd(1, 16'h0, "R1 mode zero clears pwm flag");
      exp_out(1'b0, "R1 pwm out low when off");

      // unused mode value behaves as off
      wr(0, 16'h0027);
      cyc(8);
      exp_rd(1, 16'h0, "R1 unused mode idle");
      exp_out(1'b0, "R1 unused mode out low");
      wr(0, 16'h0000);

      cyc(2);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule